// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

The block holds two 8-bit up-counters. Each has two compare references (A and B), a sticky flag per reference, an interrupt request and one waveform output. Each channel counts pulses from one of three free-running prescaled tick inputs, picked by its clock-select field. A compare event happens when a channel steps while its counter equals a reference. The event can clear the counter, set a flag and change the output level. Software reaches every register through a simple write/read port. Channel 0 also has an external clear input.

Code 3'b100 in a channel's clock-select field joins the pair. When channel 0 holds that code, the pair counts as one 16-bit counter, with channel 0 as the upper byte and channel 1 as the lower byte. When channel 1 holds it, channel 1 counts the compare-A events of channel 0. When both hold it, counting stops.

Register address: bit 3 selects the channel, bits 2:0 select the register. The registers are 0 control, 1 status, 2 counter, 3 reference A and 4 reference B. All other offsets read as zero.

Top module: `dual_timer8`

## Requirements
- R1: After reset, every counter and every control and status register reads 0, both compare references read 8'hFF, and both waveform outputs and both interrupt requests are low.
- R2: Control bits [2:0] select the count source. 000 stops the counter. 001, 010 and 011 step the counter on tick_i[0], tick_i[1] and tick_i[2]. 101 to 111 stop the counter. A compare event for a reference occurs on a step taken while the counter equals that reference.
- R3: Control bits [4:3] select the clear. 00 never clears. 01 clears to zero on a compare-A event and 10 on a compare-B event; the zero replaces that step's increment. 11 clears channel 0 while ext_clr_i is high, regardless of steps. On channel 1, code 11 clears nothing.
- R4: Status bits [3:2] set the output action on a compare-A event and bits [5:4] on a compare-B event: 00 keeps the level, 01 drives low, 10 drives high, 11 toggles. When both events occur on the same step, only the A action applies.
- R5: Status bit 0 (A) and bit 1 (B) are set by their compare events. Writing 0 to a flag clears it only after a status read that returned it as 1. Writing 1 has no effect. A flag set in the same cycle as a clear stays set.
- R6: irq_o[n] is high while flag A of channel n is set with control bit 5 set, or flag B is set with control bit 6 set.
- R7: With code 100 in channel 0 only, channel 0 holds the upper byte and channel 1 the lower byte of one 16-bit counter. The counter steps with channel 1's count source, and the upper byte increments on the step where the lower byte wraps from FF to 00.
- R8: In 16-bit mode, channel 0's flags and output follow a full 16-bit comparison of the counter pair with the reference pair. Channel 1's flags and output follow the lower byte alone.
- R9: In 16-bit mode, channel 0's clear select clears both bytes on the matching 16-bit event. With code 11, both bytes clear on ext_clr_i and also on a 16-bit compare-A event. Channel 1's clear select is ignored, so the lower byte is never zeroed on its own.
- R10: With code 100 in channel 1 only, channel 1 steps once per compare-A event of channel 0. Each channel applies its own flags, outputs and clear.
- R11: With code 100 in both channels, neither counter changes except through a software write.
- R12: A software write to a counter takes effect over any step or clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clearing) |
| addr_i | input | 4 | Register address: bit 3 channel, bits 2:0 register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tick_i | input | 3 | Prescaled count-enable taps |
| ext_clr_i | input | 1 | External clear for channel 0 |
| wave_o | output | 2 | Waveform output per channel |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
Counters, flags, outputs and interrupt requests are all registered. Each takes its new value at the rising edge that samples the tick, write or external-clear input that caused it, so the change is visible one cycle after the stimulus is driven. Read data follows the address with no delay. The bench therefore drives every input just after a falling edge and samples reads 1 ns later, within the same half cycle. After each tick burst it samples the outputs at the next falling edge. Every expected counter value is worked out by counting the steps from the last written value.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    parameter int CW    = 8;
    parameter int NCH   = 2;
    parameter int NTICK = 3;
    parameter int AW    = 4;

    localparam logic [2:0] CKS_CHAIN = 3'b100;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_CMA  = 2'b01,
        CLR_CMB  = 2'b10,
        CLR_EXT  = 2'b11
    } clr_e;

    typedef enum logic [1:0] {
        OS_KEEP   = 2'b00,
        OS_LOW    = 2'b01,
        OS_HIGH   = 2'b10,
        OS_TOGGLE = 2'b11
    } os_e;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_CNT  = 3'd2,
        REG_CMPA = 3'd3,
        REG_CMPB = 3'd4
    } reg_e;

    typedef struct packed {
        logic       ie_b;
        logic       ie_a;
        logic [1:0] clr;
        logic [2:0] cks;
    } ctrl_t;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmpa;
        logic [CW-1:0] cmpb;
        ctrl_t         ctrl;
        logic          flag_a;
        logic          flag_b;
        logic [1:0]    os_a;
        logic [1:0]    os_b;
        logic          arm_a;
        logic          arm_b;
        logic          wave;
    } chan_t;

    typedef struct packed {
        chan_t [NCH-1:0] ch;
    } state_t;
endpackage

// File: rtl/dtmr_tick_sel.sv
module dtmr_tick_sel
    import dtmr_pkg::*;
(
    input  logic [2:0]       cks_i,
    input  logic [NTICK-1:0] tick_i,
    output logic             step_o
);
    always_comb begin
        step_o = 1'b0;
        for (int k = 0; k < NTICK; k++) begin
            if (cks_i == 3'(k + 1)) step_o = tick_i[k];
        end
    end
endmodule

// File: rtl/dtmr_cmp.sv
module dtmr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] ref_a_i,
    input  logic [W-1:0] ref_b_i,
    output logic         eq_a_o,
    output logic         eq_b_o
);
    assign eq_a_o = (cnt_i == ref_a_i);
    assign eq_b_o = (cnt_i == ref_b_i);
endmodule

// File: rtl/dtmr_wave.sv
module dtmr_wave
    import dtmr_pkg::*;
(
    input  logic       ev_a_i,
    input  logic       ev_b_i,
    input  logic [1:0] os_a_i,
    input  logic [1:0] os_b_i,
    input  logic       level_i,
    output logic       level_o
);
    logic [1:0] act;

    always_comb begin
        act = OS_KEEP;
        if (ev_a_i)      act = os_a_i;
        else if (ev_b_i) act = os_b_i;
        case (os_e'(act))
            OS_LOW:    level_o = 1'b0;
            OS_HIGH:   level_o = 1'b1;
            OS_TOGGLE: level_o = ~level_i;
            default:   level_o = level_i;
        endcase
    end
endmodule

// File: rtl/dual_timer8.sv
module dual_timer8
    import dtmr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [CW-1:0]    wdata_i,
    output logic [CW-1:0]    rdata_o,
    input  logic [NTICK-1:0] tick_i,
    input  logic             ext_clr_i,
    output logic [NCH-1:0]   wave_o,
    output logic [NCH-1:0]   irq_o
);
    state_t q, d;

    logic [NCH-1:0] step_nat, eq_a8, eq_b8, ev_a, ev_b, wave_nx, chain_sel;
    logic [NCH-1:0] wsel, rsel;
    logic           eq_a16, eq_b16;
    logic           chain16, chain_cm, lock;
    logic           step0, step1, ev_a0, ev_b0, ev_a1, ev_b1;
    logic           ext0, mclr0, mclr1;
    logic           xch;
    logic [2:0]     xreg;
    logic [CW-1:0]  cnt_hi, cnt_lo;
    logic           clr0_is_ext;
    logic [2*NCH-1:0] flag_vec;

    // per-channel count source, byte compare and waveform update
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign chain_sel[c] = (q.ch[c].ctrl.cks == CKS_CHAIN);

        dtmr_tick_sel u_tsel (
            .cks_i  (q.ch[c].ctrl.cks),
            .tick_i (tick_i),
            .step_o (step_nat[c])
        );

        dtmr_cmp #(.W(CW)) u_cmp (
            .cnt_i   (q.ch[c].cnt),
            .ref_a_i (q.ch[c].cmpa),
            .ref_b_i (q.ch[c].cmpb),
            .eq_a_o  (eq_a8[c]),
            .eq_b_o  (eq_b8[c])
        );

        dtmr_wave u_wave (
            .ev_a_i  (ev_a[c]),
            .ev_b_i  (ev_b[c]),
            .os_a_i  (q.ch[c].os_a),
            .os_b_i  (q.ch[c].os_b),
            .level_i (q.ch[c].wave),
            .level_o (wave_nx[c])
        );

        assign wave_o[c] = q.ch[c].wave;
        assign irq_o[c]  = (q.ch[c].flag_a & q.ch[c].ctrl.ie_a)
                         | (q.ch[c].flag_b & q.ch[c].ctrl.ie_b);
        assign flag_vec[2*c +: 2] = {q.ch[c].flag_b, q.ch[c].flag_a};
    end

    // full-width compare of the joined pair, channel 0 as upper byte
    dtmr_cmp #(.W(2*CW)) u_cmp16 (
        .cnt_i   ({q.ch[0].cnt,  q.ch[1].cnt}),
        .ref_a_i ({q.ch[0].cmpa, q.ch[1].cmpa}),
        .ref_b_i ({q.ch[0].cmpb, q.ch[1].cmpb}),
        .eq_a_o  (eq_a16),
        .eq_b_o  (eq_b16)
    );

    assign chain16  = chain_sel[0] & ~chain_sel[1];
    assign chain_cm = chain_sel[1] & ~chain_sel[0];
    assign lock     = chain_sel[0] &  chain_sel[1];

    assign cnt_hi      = q.ch[0].cnt;
    assign cnt_lo      = q.ch[1].cnt;
    assign clr0_is_ext = (q.ch[0].ctrl.clr == CLR_EXT);

    // step and compare-event network; channel 1 may hang off channel 0
    always_comb begin
        step0 = lock ? 1'b0 : (chain16 ? step_nat[1] : step_nat[0]);
        ev_a0 = step0 & (chain16 ? eq_a16 : eq_a8[0]);
        ev_b0 = step0 & (chain16 ? eq_b16 : eq_b8[0]);
        step1 = lock ? 1'b0 : (chain_cm ? ev_a0 : step_nat[1]);
        ev_a1 = step1 & eq_a8[1];
        ev_b1 = step1 & eq_b8[1];
        ev_a  = {ev_a1, ev_a0};
        ev_b  = {ev_b1, ev_b0};
    end

    // next-state computation
    always_comb begin
        xch  = addr_i[AW-1];
        xreg = addr_i[2:0];
        for (int c = 0; c < NCH; c++) begin
            wsel[c] = wr_en_i && (int'(xch) == c);
            rsel[c] = rd_en_i && (int'(xch) == c);
        end

        ext0  = clr0_is_ext && ext_clr_i && !lock;
        mclr0 = ((q.ch[0].ctrl.clr == CLR_CMA) && ev_a0)
              | ((q.ch[0].ctrl.clr == CLR_CMB) && ev_b0)
              | (chain16 && clr0_is_ext && ev_a0);
        mclr1 = !chain16 && (((q.ch[1].ctrl.clr == CLR_CMA) && ev_a1)
                           | ((q.ch[1].ctrl.clr == CLR_CMB) && ev_b1));

        d = q;

        for (int c = 0; c < NCH; c++) begin
            d.ch[c].flag_a = ev_a[c] | (q.ch[c].flag_a &
                ~(wsel[c] && (xreg == REG_STAT) && !wdata_i[0] && q.ch[c].arm_a));
            d.ch[c].flag_b = ev_b[c] | (q.ch[c].flag_b &
                ~(wsel[c] && (xreg == REG_STAT) && !wdata_i[1] && q.ch[c].arm_b));
            if (wsel[c] && (xreg == REG_STAT)) begin
                d.ch[c].arm_a = 1'b0;
                d.ch[c].arm_b = 1'b0;
            end else if (rsel[c] && (xreg == REG_STAT)) begin
                d.ch[c].arm_a = q.ch[c].arm_a | q.ch[c].flag_a;
                d.ch[c].arm_b = q.ch[c].arm_b | q.ch[c].flag_b;
            end
            d.ch[c].wave = wave_nx[c];
        end

        if (ext0) begin
            d.ch[0].cnt = '0;
        end else if (step0) begin
            if (mclr0)
                d.ch[0].cnt = '0;
            else if (chain16 && (q.ch[1].cnt != '1))
                d.ch[0].cnt = q.ch[0].cnt;
            else
                d.ch[0].cnt = q.ch[0].cnt + CW'(1);
        end

        if (chain16 && ext0) begin
            d.ch[1].cnt = '0;
        end else if (step1) begin
            if (chain16 ? mclr0 : mclr1)
                d.ch[1].cnt = '0;
            else
                d.ch[1].cnt = q.ch[1].cnt + CW'(1);
        end

        // software writes override hardware updates
        for (int c = 0; c < NCH; c++) begin
            if (wsel[c]) begin
                case (reg_e'(xreg))
                    REG_CTRL: d.ch[c].ctrl = ctrl_t'(wdata_i[6:0]);
                    REG_STAT: begin
                        d.ch[c].os_a = wdata_i[3:2];
                        d.ch[c].os_b = wdata_i[5:4];
                    end
                    REG_CNT:  d.ch[c].cnt  = wdata_i;
                    REG_CMPA: d.ch[c].cmpa = wdata_i;
                    REG_CMPB: d.ch[c].cmpb = wdata_i;
                    default: ;
                endcase
            end
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        case (reg_e'(addr_i[2:0]))
            REG_CTRL: rdata_o = {1'b0, q.ch[addr_i[AW-1]].ctrl};
            REG_STAT: rdata_o = {2'b00, q.ch[addr_i[AW-1]].os_b, q.ch[addr_i[AW-1]].os_a,
                                 q.ch[addr_i[AW-1]].flag_b, q.ch[addr_i[AW-1]].flag_a};
            REG_CNT:  rdata_o = q.ch[addr_i[AW-1]].cnt;
            REG_CMPA: rdata_o = q.ch[addr_i[AW-1]].cmpa;
            REG_CMPB: rdata_o = q.ch[addr_i[AW-1]].cmpb;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
            for (int c = 0; c < NCH; c++) begin
                q.ch[c].cmpa <= '1;
                q.ch[c].cmpb <= '1;
            end
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
    import dtmr_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             ext_clr_i,
    input logic             lock_i,
    input logic             chain16_i,
    input logic             clr0_ext_i,
    input logic [CW-1:0]    cnt_hi_i,
    input logic [CW-1:0]    cnt_lo_i,
    input logic [2*NCH-1:0] flags_i,
    input logic [NCH-1:0]   irq_i
);
    assert_lock_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && !wr_en_i) |=> (cnt_hi_i == $past(cnt_hi_i) && cnt_lo_i == $past(cnt_lo_i)));

    assert_low_byte_not_alone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chain16_i && !wr_en_i && !(clr0_ext_i && ext_clr_i))
        |=> (cnt_lo_i == $past(cnt_lo_i) || cnt_lo_i == $past(cnt_lo_i) + CW'(1)
             || {cnt_hi_i, cnt_lo_i} == '0));

    assert_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chain16_i && !wr_en_i && cnt_lo_i == '1)
        |=> (cnt_lo_i != '0 || cnt_hi_i != $past(cnt_hi_i) || cnt_hi_i == '0));

    for (genvar g = 0; g < 2*NCH; g++) begin : g_flag
        assert_flag_sw_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flags_i[g]) |-> $past(wr_en_i));
    end

    for (genvar g = 0; g < NCH; g++) begin : g_irq
        assert_irq_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(irq_i[g]) |-> $past(wr_en_i));
    end
endmodule

bind dual_timer8 dtmr_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .ext_clr_i  (ext_clr_i),
    .lock_i     (lock),
    .chain16_i  (chain16),
    .clr0_ext_i (clr0_is_ext),
    .cnt_hi_i   (cnt_hi),
    .cnt_lo_i   (cnt_lo),
    .flags_i    (flag_vec),
    .irq_i      (irq_o)
);

// File: tb/dual_timer8_bench.sv
module dual_timer8_bench;
    import dtmr_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [CW-1:0]    wdata = '0;
    logic [CW-1:0]    rdata;
    logic [NTICK-1:0] tick = '0;
    logic             ext = 1'b0;
    logic [NCH-1:0]   wave;
    logic [NCH-1:0]   irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dual_timer8 u_dual_timer8 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .tick_i(tick),
        .ext_clr_i(ext), .wave_o(wave), .irq_o(irq)
    );

    // op 0 write, 1 read and compare, 2 run n cycles of tick_i[0]
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 4'h0, 8'h09, 8'h00},
        {2'd0, 4'h3, 8'h03, 8'h00},
        {2'd0, 4'h1, 8'h0C, 8'h00},
        {2'd2, 4'h0, 8'd3,  8'h00},
        {2'd1, 4'h2, 8'h00, 8'h03},
        {2'd1, 4'h1, 8'h00, 8'h0C},
        {2'd2, 4'h0, 8'd1,  8'h00},
        {2'd1, 4'h2, 8'h00, 8'h00},
        {2'd1, 4'h1, 8'h00, 8'h0D},
        {2'd0, 4'h1, 8'h0C, 8'h00},
        {2'd1, 4'h1, 8'h00, 8'h0C},
        {2'd2, 4'h0, 8'd4,  8'h00},
        {2'd1, 4'h1, 8'h00, 8'h0D}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string req);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, rdata, e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run(input int k, input int n);
        tick[k] = 1'b1;
        repeat (n) @(negedge clk);
        tick = '0;
    endtask

    task automatic ext_pulse();
        ext = 1'b1;
        @(negedge clk);
        ext = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, 8'h00, "R1 ctrl0");
        rd(4'h2, 8'h00, "R1 cnt0");
        rd(4'h3, 8'hFF, "R1 cmpa0");
        rd(4'hC, 8'hFF, "R1 cmpb1");
        check("R1 wave", {6'd0, wave}, 8'h00);
        check("R1 irq", {6'd0, irq}, 8'h00);

        // table walk: R2 R3 R4 R5 on channel 0
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][21:20])
                2'd0: wr(VEC[i][19:16], VEC[i][15:8]);
                2'd1: rd(VEC[i][19:16], VEC[i][7:0], "table R2 R3 R5");
                default: run(0, int'(VEC[i][15:8]));
            endcase
        end
        check("R4 toggle after table", {7'd0, wave[0]}, 8'h00);

        // R5 clear needs a prior read
        wr(4'h1, 8'h0C);
        run(0, 4);
        wr(4'h1, 8'h0C);
        rd(4'h1, 8'h0D, "R5 clear without read ignored");
        wr(4'h1, 8'h0C);
        rd(4'h1, 8'h0C, "R5 clear after read");

        // R6 interrupt request
        wr(4'h0, 8'h29);
        run(0, 4);
        check("R6 irq set", {7'd0, irq[0]}, 8'h01);
        rd(4'h1, 8'h0D, "R6 flag");
        wr(4'h1, 8'h0C);
        check("R6 irq cleared", {7'd0, irq[0]}, 8'h00);

        // R4 A over B, then B alone drives low
        wr(4'h0, 8'h01);
        wr(4'h2, 8'h00);
        wr(4'h3, 8'h02);
        wr(4'h4, 8'h02);
        wr(4'h1, 8'h18);
        run(0, 3);
        check("R4 A priority high", {7'd0, wave[0]}, 8'h01);
        wr(4'h4, 8'h05);
        run(0, 3);
        check("R4 B drives low", {7'd0, wave[0]}, 8'h00);
        rd(4'h2, 8'h06, "R2 no clear select");

        // R3 external clear on channel 0 only
        wr(4'h0, 8'h19);
        ext_pulse();
        rd(4'h2, 8'h00, "R3 ext clears ch0");
        wr(4'h8, 8'h19);
        wr(4'hA, 8'h05);
        ext_pulse();
        rd(4'hA, 8'h05, "R3 ext ignored by ch1");

        // R7 R8 R9 16-bit mode
        wr(4'h8, 8'h09);
        wr(4'h0, 8'h0C);
        wr(4'h3, 8'h01);
        wr(4'hB, 8'h02);
        wr(4'hC, 8'h80);
        wr(4'h9, 8'h0C);
        wr(4'h2, 8'h00);
        wr(4'hA, 8'hFE);
        run(0, 2);
        rd(4'h2, 8'h01, "R7 upper carry");
        rd(4'hA, 8'h00, "R7 lower wrap");
        run(0, 3);
        rd(4'h2, 8'h00, "R9 16-bit clear hi");
        rd(4'hA, 8'h00, "R9 16-bit clear lo");
        check("R8 out0 on 16-bit match", {7'd0, wave[0]}, 8'h01);
        check("R8 out1 on low match", {7'd0, wave[1]}, 8'h01);
        run(0, 3);
        rd(4'hA, 8'h03, "R9 ch1 clear ignored");
        check("R8 out1 low-byte only", {7'd0, wave[1]}, 8'h00);
        check("R8 out0 unchanged", {7'd0, wave[0]}, 8'h01);
        rd(4'h9, 8'h0D, "R8 ch1 flag");

        // R9 clear select 11 also clears on 16-bit match A
        wr(4'h0, 8'h1C);
        wr(4'h2, 8'h01);
        wr(4'hA, 8'h02);
        run(0, 1);
        rd(4'h2, 8'h00, "R9 ext-select match clear hi");
        rd(4'hA, 8'h00, "R9 ext-select match clear lo");
        wr(4'h2, 8'h03);
        wr(4'hA, 8'h40);
        ext_pulse();
        rd(4'hA, 8'h00, "R9 ext clears lower byte");

        // R10 compare-match counter mode
        wr(4'h0, 8'h09);
        wr(4'h3, 8'h01);
        wr(4'h8, 8'h04);
        wr(4'h2, 8'h00);
        wr(4'hA, 8'h00);
        run(0, 6);
        rd(4'hA, 8'h03, "R10 ch1 counts A events");
        rd(4'h2, 8'h00, "R10 ch0 own clear");

        // R11 both chained
        wr(4'h2, 8'h07);
        wr(4'h0, 8'h04);
        run(0, 5);
        rd(4'h2, 8'h07, "R11 ch0 held");
        rd(4'hA, 8'h03, "R11 ch1 held");

        // R2 tap selection
        wr(4'h8, 8'h00);
        wr(4'h0, 8'h02);
        wr(4'h2, 8'h00);
        run(0, 3);
        rd(4'h2, 8'h00, "R2 other tap ignored");
        run(1, 2);
        rd(4'h2, 8'h02, "R2 tap 1 counts");

        // R12 write beats a step
        wr(4'h0, 8'h01);
        tick[0] = 1'b1;
        wr(4'h2, 8'h55);
        tick = '0;
        rd(4'h2, 8'h55, "R12 write priority");

        summary();
        $finish;
    end
endmodule